// File: doc/BRIEF.md
# Serial Programming Command Decoder

This block sits on the slave side of a three-wire serial programming link. Its inputs are a serial clock and a serial data line, and its output is a serial data-out line. It lets an external programmer read, write and erase the on-chip code memory and data memory. The programmer sends fixed 32-bit frames made of four bytes: an opcode, an address high byte, an address low byte, and a data byte. During a read, that last byte slot carries the returned data back on the data-out line instead. The serial clock and data are brought into the block's own clock domain. Bits are taken on each falling edge of the serial clock. The block then decodes each frame into requests on a simple memory port, and that port signals completion with a done pulse.

Two kinds of write exist. A byte write goes straight to memory. A page load collects a whole page in a local buffer before anything is written. A code page is 64 bytes and a data page is 32 bytes. After the last byte of a page arrives, the buffered page is written out to memory as one burst. The decoder never erases a location before it writes it. Writing a location again therefore needs an explicit chip erase first.

While any memory operation is in flight, the block reports busy. Any frame that begins during that time is dropped as a whole.

Top module: `isp_decoder`

## Requirements
- R1: A frame is 32 bits, taken MSB first, one bit on each falling edge of `sck`. While `prog_en` is low, the bit count returns to the start of a frame and `miso` is driven low on the next clock.
- R2: Opcode 0x20 reads code memory (`mem_sel`=0) and opcode 0xA0 reads data memory (`mem_sel`=1). After the 24th falling edge, a read (`mem_op`=0) is issued at the address carried in bytes 2 and 3. The returned byte then appears on `miso`: bit 7 after the 24th falling edge, and bit 7-k after falling edge 24+k.
- R3: Opcode 0x40 writes a code byte and opcode 0xC0 writes a data byte. Each issues exactly one write (`mem_op`=1) after the 32nd falling edge, using the frame's address and data byte. No erase goes with it.
- R4: Opcode 0xAC issues one erase (`mem_op`=2, address 0). It also throws away any partly loaded page.
- R5: Opcode 0x50 loads one byte into a 64-byte code page. The first frame of a page sets the page and the starting offset. Later frames ignore their address field. The offset steps up by one and wraps within the page. No memory access happens until 64 bytes are held. Then 64 writes go out at offsets 0 to 63 of the page, in that order.
- R6: Opcode 0xD0 does the same for a 32-byte data page. A page-load frame for the other memory starts a fresh page.
- R7: `busy` is high from the moment a memory request is issued until the done of its last access. A frame whose first bit arrives while `busy` is high causes no memory access at all.
- R8: A frame with any other opcode causes no memory access and leaves a partly loaded page intact.
- R9: `mem_req`, `mem_op`, `mem_sel`, `mem_addr` and `mem_wdata` hold steady from the moment a request is issued until `mem_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_en | input | 1 | Programming enable; low resets frame alignment |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial command data in |
| miso | output | 1 | Serial read data out |
| busy | output | 1 | A memory operation is in flight |
| mem_req | output | 1 | Memory request, held until done |
| mem_op | output | 2 | 0 read, 1 write, 2 chip erase |
| mem_sel | output | 1 | 0 code memory, 1 data memory |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with done |
| mem_done | input | 1 | One-cycle completion pulse |

## Verification
Read-back after byte writes to both memories is used to tell `mem_sel` routing apart from address decoding. It also shows that `miso` bit order and timing are right. Page loads are sent with a nonzero start offset and junk in the address field of later frames. In the middle of a load, an unknown-opcode frame is inserted. Together these separate offset wrap, address capture and page retention from a decoder that counts frames or uses each frame's own address. A slow memory response lets a second frame land while `busy` is high. A partial page followed by an erase shows whether the page fill is discarded, because a stale fill would start its write burst early.

// File: rtl/isp_pkg.sv
package isp_pkg;

   localparam logic [7:0] OPC_RD_CODE = 8'h20;
   localparam logic [7:0] OPC_RD_DATA = 8'hA0;
   localparam logic [7:0] OPC_WR_CODE = 8'h40;
   localparam logic [7:0] OPC_WR_DATA = 8'hC0;
   localparam logic [7:0] OPC_PG_CODE = 8'h50;
   localparam logic [7:0] OPC_PG_DATA = 8'hD0;
   localparam logic [7:0] OPC_ERASE   = 8'hAC;

   typedef enum logic [1:0] {
      MOP_READ  = 2'd0,
      MOP_WRITE = 2'd1,
      MOP_ERASE = 2'd2
   } mem_op_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_READ,
      ST_SINGLE,
      ST_COMMIT
   } ctl_state_e;

endpackage

// File: rtl/isp_sampler.sv
module isp_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic mosi,
   output logic sck_fall,
   output logic mosi_bit
);
   logic sck_c;
   logic mosi_c;
   logic sck_last;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign sck_c  = sck;
         assign mosi_c = mosi;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sck_pipe;
         logic [SYNC_STAGES-1:0] mosi_pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_pipe  <= '0;
               mosi_pipe <= '0;
            end else begin
               sck_pipe[0]  <= sck;
               mosi_pipe[0] <= mosi;
               for (int k = 1; k < SYNC_STAGES; k++) begin
                  sck_pipe[k]  <= sck_pipe[k-1];
                  mosi_pipe[k] <= mosi_pipe[k-1];
               end
            end
         end
         assign sck_c  = sck_pipe[SYNC_STAGES-1];
         assign mosi_c = mosi_pipe[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_last <= 1'b0;
      else        sck_last <= sck_c;
   end

   assign sck_fall = sck_last & ~sck_c;
   assign mosi_bit = mosi_c;

endmodule

// File: rtl/isp_frame.sv
module isp_frame #(
   parameter int FRAME_BITS = 32,
   parameter int HDR_BITS   = 24
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  enable,
   input  logic                  bit_strobe,
   input  logic                  bit_val,
   input  logic                  load_rd,
   input  logic [7:0]            rd_data,
   output logic                  start,
   output logic                  hdr_valid,
   output logic                  frame_valid,
   output logic [FRAME_BITS-1:0] frame_word,
   output logic                  miso
);
   localparam int CNT_W = $clog2(FRAME_BITS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_BITS - 1);
   localparam logic [CNT_W-1:0] HDR_N    = CNT_W'(HDR_BITS);

   logic [CNT_W-1:0]      cnt;
   logic [FRAME_BITS-1:0] shreg;
   logic [7:0]            out_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt         <= '0;
         shreg       <= '0;
         out_sh      <= '0;
         start       <= 1'b0;
         hdr_valid   <= 1'b0;
         frame_valid <= 1'b0;
      end else begin
         start       <= 1'b0;
         hdr_valid   <= 1'b0;
         frame_valid <= 1'b0;
         if (!enable) begin
            cnt    <= '0;
            out_sh <= '0;
         end else begin
            if (load_rd) begin
               out_sh <= rd_data;
            end
            if (bit_strobe) begin
               shreg       <= {shreg[FRAME_BITS-2:0], bit_val};
               start       <= (cnt == '0);
               hdr_valid   <= (cnt == HDR_LAST);
               frame_valid <= (cnt == CNT_LAST);
               cnt         <= (cnt == CNT_LAST) ? '0 : cnt + 1'b1;
               if (cnt == '0) begin
                  out_sh <= '0;
               end else if (cnt >= HDR_N && !load_rd) begin
                  out_sh <= {out_sh[6:0], 1'b0};
               end
            end
         end
      end
   end

   assign frame_word = shreg;
   assign miso       = out_sh[7];

endmodule

// File: rtl/isp_page_buf.sv
module isp_page_buf #(
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/isp_ctrl.sv
module isp_ctrl
   import isp_pkg::*;
#(
   parameter int ADDR_W    = 14,
   parameter int CODE_PAGE = 64,
   parameter int DATA_PAGE = 32,
   localparam int OFF_W    = $clog2(CODE_PAGE),
   localparam int HI_W     = ADDR_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              hdr_valid,
   input  logic              frame_valid,
   input  logic [31:0]       frame_word,
   input  logic [7:0]        mem_rdata,
   input  logic              mem_done,
   input  logic [7:0]        buf_rdata,
   output logic              busy,
   output logic              load_rd,
   output logic [7:0]        rd_data,
   output logic              mem_req,
   output mem_op_e           mem_op,
   output logic              mem_sel,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              buf_we,
   output logic [OFF_W-1:0]  buf_waddr,
   output logic [7:0]        buf_wdata,
   output logic [OFF_W-1:0]  buf_raddr
);
   localparam logic [OFF_W-1:0] CODE_MASK = OFF_W'(CODE_PAGE - 1);
   localparam logic [OFF_W-1:0] DATA_MASK = OFF_W'(DATA_PAGE - 1);
   localparam logic [OFF_W:0]   CODE_LAST = (OFF_W+1)'(CODE_PAGE - 1);
   localparam logic [OFF_W:0]   DATA_LAST = (OFF_W+1)'(DATA_PAGE - 1);

   ctl_state_e        st;
   logic              drop;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        wdata_q;

   logic              pg_active;
   logic              pg_sel;
   logic [ADDR_W-1:0] pg_base;
   logic [OFF_W-1:0]  pg_off;
   logic [OFF_W:0]    pg_cnt;
   logic [OFF_W-1:0]  cm_idx;

   logic [7:0]  h_opc;
   logic [15:0] h_addr;
   logic [7:0]  f_opc;
   logic [15:0] f_addr;
   logic [7:0]  f_data;

   assign h_opc  = frame_word[23:16];
   assign h_addr = frame_word[15:0];
   assign f_opc  = frame_word[31:24];
   assign f_addr = frame_word[23:8];
   assign f_data = frame_word[7:0];

   logic             rd_hit;
   logic             wr_hit;
   logic             page_hit;
   logic             new_sel;
   logic             pg_first;
   logic [OFF_W-1:0] new_mask;
   logic [OFF_W:0]   new_last;
   logic [OFF_W-1:0] wr_off;
   logic [OFF_W:0]   fill;
   logic             pg_full;

   always_comb begin
      rd_hit   = hdr_valid && !drop && (st == ST_IDLE) &&
                 (h_opc == OPC_RD_CODE || h_opc == OPC_RD_DATA);
      wr_hit   = frame_valid && !drop && (st == ST_IDLE) &&
                 (f_opc == OPC_WR_CODE || f_opc == OPC_WR_DATA);
      page_hit = frame_valid && !drop && (st == ST_IDLE) &&
                 (f_opc == OPC_PG_CODE || f_opc == OPC_PG_DATA);
      new_sel  = (f_opc == OPC_PG_DATA);
      pg_first = !pg_active || (pg_sel != new_sel);
      new_mask = new_sel ? DATA_MASK : CODE_MASK;
      new_last = new_sel ? DATA_LAST : CODE_LAST;
      wr_off   = pg_first ? (f_addr[OFF_W-1:0] & new_mask) : pg_off;
      fill     = pg_first ? '0 : pg_cnt;
      pg_full  = (fill == new_last);
   end

   assign buf_we    = page_hit;
   assign buf_waddr = wr_off;
   assign buf_wdata = f_data;
   assign buf_raddr = cm_idx;

   logic [OFF_W-1:0]  cm_mask;
   logic [OFF_W:0]    cm_last;
   logic [ADDR_W-1:0] cm_addr;

   always_comb begin
      cm_mask = mem_sel ? DATA_MASK : CODE_MASK;
      cm_last = mem_sel ? DATA_LAST : CODE_LAST;
      cm_addr = (pg_base & ~{{HI_W{1'b0}}, cm_mask}) | {{HI_W{1'b0}}, cm_idx};
   end

   assign mem_addr  = (st == ST_COMMIT) ? cm_addr   : addr_q;
   assign mem_wdata = (st == ST_COMMIT) ? buf_rdata : wdata_q;
   assign busy      = (st != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         drop      <= 1'b0;
         addr_q    <= '0;
         wdata_q   <= '0;
         mem_req   <= 1'b0;
         mem_op    <= MOP_READ;
         mem_sel   <= 1'b0;
         load_rd   <= 1'b0;
         rd_data   <= '0;
         pg_active <= 1'b0;
         pg_sel    <= 1'b0;
         pg_base   <= '0;
         pg_off    <= '0;
         pg_cnt    <= '0;
         cm_idx    <= '0;
      end else begin
         load_rd <= 1'b0;
         if (start) drop <= busy;
         unique case (st)
            ST_IDLE: begin
               if (rd_hit) begin
                  st      <= ST_READ;
                  mem_req <= 1'b1;
                  mem_op  <= MOP_READ;
                  mem_sel <= (h_opc == OPC_RD_DATA);
                  addr_q  <= h_addr[ADDR_W-1:0];
               end else if (wr_hit) begin
                  st      <= ST_SINGLE;
                  mem_req <= 1'b1;
                  mem_op  <= MOP_WRITE;
                  mem_sel <= (f_opc == OPC_WR_DATA);
                  addr_q  <= f_addr[ADDR_W-1:0];
                  wdata_q <= f_data;
               end else if (frame_valid && !drop && f_opc == OPC_ERASE) begin
                  st        <= ST_SINGLE;
                  mem_req   <= 1'b1;
                  mem_op    <= MOP_ERASE;
                  mem_sel   <= 1'b0;
                  addr_q    <= '0;
                  wdata_q   <= '0;
                  pg_active <= 1'b0;
               end else if (page_hit) begin
                  if (pg_first) pg_base <= f_addr[ADDR_W-1:0];
                  pg_sel <= new_sel;
                  if (pg_full) begin
                     st        <= ST_COMMIT;
                     pg_active <= 1'b0;
                     mem_req   <= 1'b1;
                     mem_op    <= MOP_WRITE;
                     mem_sel   <= new_sel;
                     cm_idx    <= '0;
                  end else begin
                     pg_active <= 1'b1;
                     pg_off    <= (wr_off + 1'b1) & new_mask;
                     pg_cnt    <= fill + 1'b1;
                  end
               end
            end
            ST_READ: begin
               if (mem_done) begin
                  st      <= ST_IDLE;
                  mem_req <= 1'b0;
                  load_rd <= 1'b1;
                  rd_data <= mem_rdata;
               end
            end
            ST_SINGLE: begin
               if (mem_done) begin
                  st      <= ST_IDLE;
                  mem_req <= 1'b0;
               end
            end
            ST_COMMIT: begin
               if (mem_done) begin
                  if ({1'b0, cm_idx} == cm_last) begin
                     st      <= ST_IDLE;
                     mem_req <= 1'b0;
                  end else begin
                     cm_idx <= cm_idx + 1'b1;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/isp_decoder.sv
module isp_decoder
   import isp_pkg::*;
#(
   parameter int ADDR_W      = 14,
   parameter int CODE_PAGE   = 64,
   parameter int DATA_PAGE   = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_en,
   input  logic              sck,
   input  logic              mosi,
   output logic              miso,
   output logic              busy,
   output logic              mem_req,
   output logic [1:0]        mem_op,
   output logic              mem_sel,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   input  logic              mem_done
);
   localparam int OFF_W = $clog2(CODE_PAGE);

   generate
      if (ADDR_W < 8 || ADDR_W > 16) begin : g_bad_addr
         $error("ADDR_W must lie in 8..16");
      end
      if (CODE_PAGE < 2 || (CODE_PAGE & (CODE_PAGE - 1)) != 0) begin : g_bad_code
         $error("CODE_PAGE must be a power of two of at least 2");
      end
      if (DATA_PAGE < 2 || (DATA_PAGE & (DATA_PAGE - 1)) != 0) begin : g_bad_data
         $error("DATA_PAGE must be a power of two of at least 2");
      end
      if (DATA_PAGE > CODE_PAGE) begin : g_bad_order
         $error("DATA_PAGE may not exceed CODE_PAGE");
      end
      if (OFF_W >= ADDR_W) begin : g_bad_fit
         $error("a code page must be smaller than the address space");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic             sck_fall;
   logic             mosi_bit;
   logic             start;
   logic             hdr_valid;
   logic             frame_valid;
   logic [31:0]      frame_word;
   logic             load_rd;
   logic [7:0]       rd_data;
   mem_op_e          op_e;
   logic             buf_we;
   logic [OFF_W-1:0] buf_waddr;
   logic [7:0]       buf_wdata;
   logic [OFF_W-1:0] buf_raddr;
   logic [7:0]       buf_rdata;

   isp_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk      (clk),
      .rst_n    (rst_n),
      .sck      (sck),
      .mosi     (mosi),
      .sck_fall (sck_fall),
      .mosi_bit (mosi_bit)
   );

   isp_frame #(.FRAME_BITS(32), .HDR_BITS(24)) u_frame (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (prog_en),
      .bit_strobe  (sck_fall),
      .bit_val     (mosi_bit),
      .load_rd     (load_rd),
      .rd_data     (rd_data),
      .start       (start),
      .hdr_valid   (hdr_valid),
      .frame_valid (frame_valid),
      .frame_word  (frame_word),
      .miso        (miso)
   );

   isp_ctrl #(
      .ADDR_W    (ADDR_W),
      .CODE_PAGE (CODE_PAGE),
      .DATA_PAGE (DATA_PAGE)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .hdr_valid   (hdr_valid),
      .frame_valid (frame_valid),
      .frame_word  (frame_word),
      .mem_rdata   (mem_rdata),
      .mem_done    (mem_done),
      .buf_rdata   (buf_rdata),
      .busy        (busy),
      .load_rd     (load_rd),
      .rd_data     (rd_data),
      .mem_req     (mem_req),
      .mem_op      (op_e),
      .mem_sel     (mem_sel),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .buf_we      (buf_we),
      .buf_waddr   (buf_waddr),
      .buf_wdata   (buf_wdata),
      .buf_raddr   (buf_raddr)
   );

   isp_page_buf #(.DEPTH(CODE_PAGE)) u_buf (
      .clk   (clk),
      .we    (buf_we),
      .waddr (buf_waddr),
      .wdata (buf_wdata),
      .raddr (buf_raddr),
      .rdata (buf_rdata)
   );

   assign mem_op = op_e;

endmodule

// File: rtl/isp_decoder_chk.sv
module isp_decoder_chk #(
   parameter int ADDR_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              prog_en,
   input logic              miso,
   input logic              busy,
   input logic              mem_req,
   input logic [1:0]        mem_op,
   input logic              mem_sel,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [7:0]        mem_wdata,
   input logic              mem_done
);

   AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_done) |=> (mem_req && $stable(mem_op) && $stable(mem_sel) && $stable(mem_addr) && $stable(mem_wdata))); // R9

   AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy); // R7

   AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(mem_done)); // R7

   AST_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_op != 2'd3)); // R9

   AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_en |=> !miso); // R1

endmodule

bind isp_decoder isp_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .prog_en   (prog_en),
   .miso      (miso),
   .busy      (busy),
   .mem_req   (mem_req),
   .mem_op    (mem_op),
   .mem_sel   (mem_sel),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_done  (mem_done)
);

// File: tb/tb_isp_decoder.sv
module tb_isp_decoder;
   localparam int ADDR_W = 14;
   localparam int HALF   = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              prog_en = 1'b0;
   logic              sck = 1'b0;
   logic              mosi = 1'b0;
   logic              miso;
   logic              busy;
   logic              mem_req;
   logic [1:0]        mem_op;
   logic              mem_sel;
   logic [ADDR_W-1:0] mem_addr;
   logic [7:0]        mem_wdata;
   logic [7:0]        mem_rdata = 8'h00;
   logic              mem_done = 1'b0;

   always #10 clk = ~clk;

   isp_decoder #(.ADDR_W(ADDR_W)) dut (
      .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .sck(sck), .mosi(mosi),
      .miso(miso), .busy(busy), .mem_req(mem_req), .mem_op(mem_op),
      .mem_sel(mem_sel), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_done(mem_done)
   );

   int checks = 0;
   int errors = 0;
   int lat    = 2;
   int wcnt   = 0;

   typedef struct {
      int    op;
      int    sel;
      int    addr;
      int    data;
      string tag;
   } exp_t;

   exp_t       exp_q[$];
   logic [7:0] code_m[int];
   logic [7:0] data_m[int];

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, expv);
      end
   endtask

   task automatic expect_op(input int op, input int sel, input int addr, input int data, input string tag);
      exp_t e;
      e.op = op; e.sel = sel; e.addr = addr; e.data = data; e.tag = tag;
      exp_q.push_back(e);
   endtask

   // reference memory and request comparison, evaluated on every falling clock edge
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_done = 1'b0;
         wcnt = 0;
      end else if (mem_done) begin
         mem_done = 1'b0;
         wcnt = 0;
      end else if (mem_req) begin
         if (wcnt >= lat) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R8 unexpected memory request op", int'(mem_op), -1);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(int'(mem_op) == e.op, {e.tag, " op"}, int'(mem_op), e.op);
               chk(int'(mem_sel) == e.sel, {e.tag, " sel"}, int'(mem_sel), e.sel);
               chk(int'(mem_addr) == e.addr, {e.tag, " addr"}, int'(mem_addr), e.addr);
               if (e.op == 1) chk(int'(mem_wdata) == e.data, {e.tag, " wdata"}, int'(mem_wdata), e.data);
            end
            case (mem_op)
               2'd0: begin
                  if (mem_sel) mem_rdata = data_m.exists(int'(mem_addr)) ? data_m[int'(mem_addr)] : 8'hFF;
                  else         mem_rdata = code_m.exists(int'(mem_addr)) ? code_m[int'(mem_addr)] : 8'hFF;
               end
               2'd1: begin
                  if (mem_sel) data_m[int'(mem_addr)] = mem_wdata;
                  else         code_m[int'(mem_addr)] = mem_wdata;
               end
               default: begin
                  code_m.delete();
                  data_m.delete();
               end
            endcase
            mem_done = 1'b1;
         end else begin
            wcnt++;
         end
      end else begin
         wcnt = 0;
      end
   end

   task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                        input logic [7:0] b3, output logic [7:0] rd);
      logic [31:0] w;
      w = {b0, b1, b2, b3};
      rd = 8'h00;
      for (int i = 0; i < 32; i++) begin
         mosi = w[31-i];
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
         repeat (HALF) @(negedge clk);
         if (i >= 23 && i <= 30) rd[30-i] = miso;
      end
   endtask

   task automatic wait_idle();
      repeat (3) @(negedge clk);
      while (busy || exp_q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic read_chk(input logic [7:0] opc, input int sel, input int addr,
                           input logic [7:0] expv, input string tag);
      logic [7:0] rd;
      expect_op(0, sel, addr, 0, tag);
      frame(opc, 8'(addr >> 8), 8'(addr), 8'h00, rd);
      chk(rd == expv, {tag, " miso data"}, int'(rd), int'(expv));
      wait_idle();
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R7 watchdog actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] rd;
      logic [7:0] pbuf [64];

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(miso == 1'b0, "R1 reset miso", int'(miso), 0);
      chk(busy == 1'b0, "R7 reset busy", int'(busy), 0);
      chk(mem_req == 1'b0, "R9 reset mem_req", int'(mem_req), 0);
      prog_en = 1'b1;
      repeat (3) @(negedge clk);

      // R3 / R2: code byte write then read back
      expect_op(1, 0, 'h0123, 'h5A, "R3 code write");
      frame(8'h40, 8'h01, 8'h23, 8'h5A, rd);
      wait_idle();
      read_chk(8'h20, 0, 'h0123, 8'h5A, "R2 code read");

      // R3 / R2: data byte write, read data vs code at same address
      expect_op(1, 1, 'h0010, 'hC3, "R3 data write");
      frame(8'hC0, 8'h00, 8'h10, 8'hC3, rd);
      wait_idle();
      read_chk(8'hA0, 1, 'h0010, 8'hC3, "R2 data read");
      read_chk(8'h20, 0, 'h0010, 8'hFF, "R2 code read sel");

      // R8: unknown opcode
      frame(8'h77, 8'h01, 8'h23, 8'h99, rd);
      repeat (6) @(negedge clk);
      chk(busy == 1'b0, "R8 busy after unknown", int'(busy), 0);
      read_chk(8'h20, 0, 'h0123, 8'h5A, "R8 content kept");

      // R5: code page, start offset 5, junk address on later frames, unknown frame mid-way
      for (int i = 0; i < 64; i++) begin
         pbuf[(5 + i) % 64] = 8'(i * 3 + 1);
      end
      for (int i = 0; i < 64; i++) begin
         if (i == 10) begin
            frame(8'h33, 8'h3F, 8'hFF, 8'h00, rd);
         end
         if (i == 63) begin
            for (int j = 0; j < 64; j++) expect_op(1, 0, 'h0240 + j, int'(pbuf[j]), "R5 page write");
         end
         if (i == 0) frame(8'h50, 8'h02, 8'h45, 8'(i * 3 + 1), rd);
         else        frame(8'h50, 8'h3F, 8'hFF, 8'(i * 3 + 1), rd);
      end
      wait_idle();
      read_chk(8'h20, 0, 'h0245, 8'h01, "R5 first offset");
      read_chk(8'h20, 0, 'h0244, 8'hBE, "R5 wrapped offset");

      // R4: partial data page then erase
      for (int i = 0; i < 3; i++) frame(8'hD0, 8'h01, 8'h00, 8'hEE, rd);
      expect_op(2, 0, 0, 0, "R4 erase");
      frame(8'hAC, 8'h00, 8'h00, 8'h00, rd);
      wait_idle();
      read_chk(8'h20, 0, 'h0123, 8'hFF, "R4 erased code");

      // R6: data page starting at offset 0x1E
      for (int i = 0; i < 32; i++) pbuf[(30 + i) % 32] = 8'(8'h80 + i);
      for (int i = 0; i < 32; i++) begin
         if (i == 31) begin
            for (int j = 0; j < 32; j++) expect_op(1, 1, 'h0060 + j, int'(pbuf[j]), "R6 page write");
         end
         frame(8'hD0, 8'h00, 8'h7E, 8'(8'h80 + i), rd);
      end
      wait_idle();
      read_chk(8'hA0, 1, 'h007E, 8'h80, "R6 first offset");
      read_chk(8'hA0, 1, 'h0060, 8'h82, "R6 wrapped offset");

      // R7: frame arriving while busy is ignored
      lat = 1500;
      expect_op(1, 0, 'h0300, 'h11, "R7 slow write");
      frame(8'h40, 8'h03, 8'h00, 8'h11, rd);
      chk(busy == 1'b1, "R7 busy during op", int'(busy), 1);
      frame(8'h40, 8'h03, 8'h01, 8'h22, rd);
      chk(busy == 1'b1, "R7 busy still", int'(busy), 1);
      wait_idle();
      lat = 2;
      chk(busy == 1'b0, "R7 busy released", int'(busy), 0);
      read_chk(8'h20, 0, 'h0301, 8'hFF, "R7 ignored write");
      read_chk(8'h20, 0, 'h0300, 8'h11, "R7 accepted write");

      // R1: disabling mid-frame restarts alignment
      for (int i = 0; i < 10; i++) begin
         mosi = 1'b1;
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
         repeat (HALF) @(negedge clk);
      end
      prog_en = 1'b0;
      repeat (4) @(negedge clk);
      chk(miso == 1'b0, "R1 miso low while disabled", int'(miso), 0);
      prog_en = 1'b1;
      repeat (4) @(negedge clk);
      read_chk(8'hA0, 1, 'h007E, 8'h80, "R1 realigned read");

      finish_run();
   end

endmodule